// File: doc/BRIEF.md
# Dual-Mode Converter Input Register

This block is the digital front end of a 16-bit digital-to-analog converter. A host loads a code word either as two bytes over a shared 8-bit bus or as a bit stream. In stream mode, bus line 0 carries the data and bus line 1 selects the bit order. The word is assembled in an input register. A separate load strobe copies it into the output register that drives the converter. Because loading is a separate step, several converters that share the load line change their output together.

All host strobes are brought into the system clock domain through synchronizer stages and are detected as edges there. A stream output presents the bit about to leave the input register, so several blocks can be chained on one data line. An active-low clear drives both registers to the code for zero volts. That code depends on the output range chosen on the lower-byte enable pin. The clear takes effect without waiting for a clock and is released on the clock.

Top module: `dac_input_front`

## Requirements
- R1: In byte mode (`ser_sel`=0), the upper-byte strobe writes `bus_d` into bits 15:8 of the input register and the lower-byte strobe writes bits 7:0. A strobe is the OR of `cs_n` with `hi_en_n` or with `lo_en_n`, and the write takes effect on the strobe's rising edge. The two halves may be written in either order, and the half that is not written keeps its value.
- R2: In stream mode (`ser_sel`=1), each rising edge of `cs_n|hi_en_n` shifts `bus_d[0]` into the input register. When `bus_d[1]`=1, the bit enters at bit 0 and the word moves toward bit 15, so the MSB is sent first. When `bus_d[1]`=0, the bit enters at bit 15 and the word moves toward bit 0. In stream mode the lower-byte strobe writes nothing.
- R3: `dac_code` changes only after a falling edge of `load_n`, which copies the input register into it. A write alone leaves `dac_code` unchanged.
- R4: `ser_out` equals bit 15 of the input register when `bus_d[1]`=1 and bit 0 when `bus_d[1]`=0. It therefore presents an earlier word in its shift order while the next word is shifted in.
- R5: While `cs_n` is high, activity on `hi_en_n`, `lo_en_n` and `bus_d` leaves the input register unchanged.
- R6: While `clr_n` is low, both registers hold the clear code, with no clock needed. The clear code is 8000h if `lo_en_n` was high and 0000h if it was low. That level must be steady for 3 clock cycles before the falling edge of `clr_n`. The registers stay cleared for 2 clock edges after `clr_n` rises.
- R7: After `rst_n` is asserted, `dac_code` is 0000h and `ser_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low |
| bus_d | input | 8 | Byte data; in stream mode bit 0 is the stream data and bit 1 is the bit order |
| cs_n | input | 1 | Chip select, active low, gates all writes |
| hi_en_n | input | 1 | Upper-byte enable; also the stream shift strobe |
| lo_en_n | input | 1 | Lower-byte enable; its level also picks the clear range |
| ser_sel | input | 1 | 1 selects stream loading |
| load_n | input | 1 | Load strobe; its falling edge copies the input register to the output |
| clr_n | input | 1 | Clear, active low, takes effect without a clock |
| dac_code | output | 16 | Converter code from the output register |
| ser_out | output | 1 | Bit about to leave the input register, used for chaining |

## Verification
On every cycle, the checker confirms four things. The output code moves only after a detected load edge. The input register moves only after a detected write edge. Each stream shift places the new bit at the end that the bit order selects. During a clear, the code equals the clear value for the range that was captured. Only the bench scenarios can show the rest: that the two byte orders end in the same word, that bus activity with chip select high is absorbed, that an earlier word comes out on `ser_out` in order, and that a load after a clear returns the clear value because the input register was cleared too.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
   // Host control lines as they pass through the synchronizer bank.
   typedef struct packed {
      logic ser;
      logic load_n;
      logic lo_n;
      logic hi_n;
      logic cs_n;
   } ctl_t;

   localparam ctl_t CTL_IDLE = '{ser: 1'b0, load_n: 1'b1, lo_n: 1'b1,
                                 hi_n: 1'b1, cs_n: 1'b1};

   // Strobe vector bit positions at the edge detector.
   localparam int STB_HI   = 0;
   localparam int STB_LO   = 1;
   localparam int STB_LOAD = 2;
   localparam int STB_W    = 3;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
   parameter int W = 8,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= {STAGES{RST_VAL}};
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/dacfe_edge.sv
module dacfe_edge #(
   parameter int W = 1,
   parameter logic [W-1:0] IDLE = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   logic [W-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= IDLE;
      else        prev <= lvl;
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign rise[i] = lvl[i] & ~prev[i];
      assign fall[i] = ~lvl[i] & prev[i];
   end
endmodule

// File: rtl/dacfe_in_reg.sv
module dacfe_in_reg #(
   parameter int WORD_W = 16,
   parameter int BUS_W = 8
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic [WORD_W-1:0] clr_val,
   input  logic              ser_mode,
   input  logic              msb_first,
   input  logic              wr_hi,
   input  logic              wr_lo,
   input  logic [BUS_W-1:0]  data,
   output logic [WORD_W-1:0] word,
   output logic              ser_out
);
   localparam int HALF = WORD_W / 2;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         word <= clr_val;
      end else if (ser_mode) begin
         if (wr_hi) begin
            if (msb_first) word <= {word[WORD_W-2:0], data[0]};
            else           word <= {data[0], word[WORD_W-1:1]};
         end
      end else begin
         if (wr_hi) word[WORD_W-1:HALF] <= data;
         if (wr_lo) word[HALF-1:0]      <= data;
      end
   end

   assign ser_out = msb_first ? word[WORD_W-1] : word[0];
endmodule

// File: rtl/dac_input_front.sv
module dac_input_front #(
   parameter int WORD_W = 16,
   parameter int BUS_W = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BUS_W-1:0]  bus_d,
   input  logic              cs_n,
   input  logic              hi_en_n,
   input  logic              lo_en_n,
   input  logic              ser_sel,
   input  logic              load_n,
   input  logic              clr_n,
   output logic [WORD_W-1:0] dac_code,
   output logic              ser_out
);
   import dacfe_pkg::*;

   localparam int CTL_W = $bits(ctl_t);
   localparam int IN_W  = BUS_W + CTL_W;
   localparam logic [WORD_W-1:0] MID_CODE = {1'b1, {(WORD_W-1){1'b0}}};
   localparam logic [IN_W-1:0]   SYNC_RST = {{BUS_W{1'b0}}, CTL_IDLE};

   if (WORD_W != 2 * BUS_W) begin : g_bad_width
      $error("WORD_W must be twice BUS_W");
   end
   if (BUS_W < 2) begin : g_bad_bus
      $error("BUS_W must carry stream data and bit order");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   // Synchronize the bus and the control lines together.
   ctl_t             ctl_in, ctl_s;
   logic [BUS_W-1:0] bus_s;
   logic [IN_W-1:0]  sync_q;

   assign ctl_in = '{ser: ser_sel, load_n: load_n, lo_n: lo_en_n,
                     hi_n: hi_en_n, cs_n: cs_n};

   dacfe_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({bus_d, ctl_in}), .q(sync_q)
   );
   assign bus_s = sync_q[IN_W-1:CTL_W];
   assign ctl_s = sync_q[CTL_W-1:0];

   // Strobe edges; the write strobes are gated by chip select.
   logic [STB_W-1:0] stb_lvl, stb_rise, stb_fall;
   assign stb_lvl[STB_HI]   = ctl_s.cs_n | ctl_s.hi_n;
   assign stb_lvl[STB_LO]   = ctl_s.cs_n | ctl_s.lo_n;
   assign stb_lvl[STB_LOAD] = ctl_s.load_n;

   dacfe_edge #(.W(STB_W), .IDLE({STB_W{1'b1}})) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(stb_lvl), .rise(stb_rise), .fall(stb_fall)
   );

   // Bus and mode as they were while the strobe was still active.
   logic [BUS_W-1:0] data_d;
   logic             ser_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_d <= '0;
         ser_d  <= 1'b0;
      end else begin
         data_d <= bus_s;
         ser_d  <= ctl_s.ser;
      end
   end

   logic wr_hi, wr_lo, load_pulse;
   assign wr_hi      = stb_rise[STB_HI];
   assign wr_lo      = stb_rise[STB_LO] & ~ser_d;
   assign load_pulse = stb_fall[STB_LOAD];

   // Clear: asserts without the clock, releases after SYNC_STAGES edges.
   logic                   clr_arst_n;
   logic [SYNC_STAGES-1:0] clr_chain;
   logic                   clr_rel_n;
   assign clr_arst_n = rst_n & clr_n;

   always_ff @(posedge clk or negedge clr_arst_n) begin
      if (!clr_arst_n) clr_chain <= '0;
      else             clr_chain <= {clr_chain[SYNC_STAGES-2:0], 1'b1};
   end
   assign clr_rel_n = clr_chain[SYNC_STAGES-1];

   // Range captured while not clearing, frozen during a clear.
   logic bip_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bip_q <= 1'b0;
      else if (clr_rel_n) bip_q <= ctl_s.lo_n;
   end

   logic [WORD_W-1:0] clr_val;
   assign clr_val = bip_q ? MID_CODE : '0;

   logic [WORD_W-1:0] in_word;
   dacfe_in_reg #(.WORD_W(WORD_W), .BUS_W(BUS_W)) u_in (
      .clk(clk), .arst_n(clr_rel_n), .clr_val(clr_val), .ser_mode(ser_d),
      .msb_first(data_d[1]), .wr_hi(wr_hi), .wr_lo(wr_lo), .data(data_d),
      .word(in_word), .ser_out(ser_out)
   );

   always_ff @(posedge clk or negedge clr_rel_n) begin
      if (!clr_rel_n)      dac_code <= clr_val;
      else if (load_pulse) dac_code <= in_word;
   end
endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker #(
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr_n,
   input logic              clr_rel_n,
   input logic              bip_q,
   input logic [WORD_W-1:0] code,
   input logic [WORD_W-1:0] in_word,
   input logic              wr_hi,
   input logic              wr_lo,
   input logic              load_pulse,
   input logic              ser_d,
   input logic              msb,
   input logic              sin
);
   localparam logic [WORD_W-1:0] MID = {1'b1, {(WORD_W-1){1'b0}}};

   // R3: output code moves only after a load edge
   a_r3_code_on_load: assert property (@(posedge clk)
      disable iff (!rst_n || !clr_rel_n)
      !$stable(code) |-> $past(load_pulse));

   // R1, R5: input register moves only after a gated write edge
   a_r1_word_on_write: assert property (@(posedge clk)
      disable iff (!rst_n || !clr_rel_n)
      !$stable(in_word) |-> $past(wr_hi || wr_lo));

   // R2: MSB-first shift enters at bit 0
   a_r2_msb_shift: assert property (@(posedge clk)
      disable iff (!rst_n || !clr_rel_n)
      (wr_hi && ser_d && msb) |=>
         (in_word == {$past(in_word[WORD_W-2:0]), $past(sin)}));

   // R2: LSB-first shift enters at bit 15
   a_r2_lsb_shift: assert property (@(posedge clk)
      disable iff (!rst_n || !clr_rel_n)
      (wr_hi && ser_d && !msb) |=>
         (in_word == {$past(sin), $past(in_word[WORD_W-1:1])}));

   // R6: clear holds both registers at the range's zero code
   a_r6_clear_code: assert property (@(posedge clk)
      disable iff (!rst_n)
      (!clr_n && !clr_rel_n) |->
         (code == (bip_q ? MID : '0) && in_word == (bip_q ? MID : '0)));
endmodule

bind dac_input_front dacfe_checker #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .clr_rel_n(clr_rel_n),
   .bip_q(bip_q), .code(dac_code), .in_word(in_word), .wr_hi(wr_hi),
   .wr_lo(wr_lo), .load_pulse(load_pulse), .ser_d(ser_d),
   .msb(data_d[1]), .sin(data_d[0])
);

// File: tb/tb_dac_input_front.sv
module tb_dac_input_front;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  bus_d;
   logic        cs_n, hi_en_n, lo_en_n, ser_sel, load_n, clr_n;
   logic [15:0] dac_code;
   logic        ser_out;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   dac_input_front dut (
      .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .cs_n(cs_n), .hi_en_n(hi_en_n),
      .lo_en_n(lo_en_n), .ser_sel(ser_sel), .load_n(load_n), .clr_n(clr_n),
      .dac_code(dac_code), .ser_out(ser_out)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic byte_wr(input bit upper, input logic [7:0] v);
      @(negedge clk);
      ser_sel = 1'b0; bus_d = v; cs_n = 1'b0;
      if (upper) hi_en_n = 1'b0; else lo_en_n = 1'b0;
      idle(4);
      hi_en_n = 1'b1; lo_en_n = 1'b1; cs_n = 1'b1;
      idle(5);
   endtask

   task automatic shift_bit(input logic b, input logic msb);
      @(negedge clk);
      ser_sel = 1'b1; bus_d = {6'b0, msb, b};
      idle(3);
      cs_n = 1'b0; hi_en_n = 1'b0;
      idle(4);
      hi_en_n = 1'b1; cs_n = 1'b1;
      idle(5);
   endtask

   task automatic pulse_load();
      @(negedge clk);
      load_n = 1'b0;
      idle(4);
      load_n = 1'b1;
      idle(5);
   endtask

   task automatic t_reset();
      chk("R7 code after reset", dac_code, 16'h0000);
      chk("R7 ser_out after reset", {15'b0, ser_out}, 16'h0000);
   endtask

   task automatic t_bytes();
      byte_wr(1'b1, 8'hA5);
      byte_wr(1'b0, 8'h3C);
      chk("R3 write without load", dac_code, 16'h0000);
      pulse_load();
      chk("R1 upper then lower", dac_code, 16'hA53C);
      byte_wr(1'b0, 8'h11);
      byte_wr(1'b1, 8'hEE);
      pulse_load();
      chk("R1 lower then upper", dac_code, 16'hEE11);
      byte_wr(1'b1, 8'h77);
      pulse_load();
      chk("R1 lower half kept", dac_code, 16'h7711);
   endtask

   task automatic t_cs_gate();
      @(negedge clk);
      cs_n = 1'b1; bus_d = 8'hFF;
      hi_en_n = 1'b0; lo_en_n = 1'b0;
      idle(4);
      hi_en_n = 1'b1; lo_en_n = 1'b1;
      idle(5);
      pulse_load();
      chk("R5 chip select high blocks writes", dac_code, 16'h7711);
   endtask

   task automatic t_serial_msb();
      logic [15:0] a = 16'hC3A5;
      logic [15:0] b = 16'h1234;
      for (int i = 15; i >= 0; i--) shift_bit(a[i], 1'b1);
      chk("R3 shift without load", dac_code, 16'h7711);
      pulse_load();
      chk("R2 msb first word", dac_code, a);
      chk("R4 ser_out msb end", {15'b0, ser_out}, {15'b0, a[15]});
      for (int i = 15; i >= 0; i--) begin
         if (i >= 12)
            chk("R4 chained bit out", {15'b0, ser_out}, {15'b0, a[i]});
         shift_bit(b[i], 1'b1);
      end
      // lower-byte strobe in stream mode must write nothing
      @(negedge clk);
      bus_d = 8'hFF; cs_n = 1'b0; lo_en_n = 1'b0;
      idle(4);
      lo_en_n = 1'b1; cs_n = 1'b1;
      idle(5);
      pulse_load();
      chk("R2 second msb word, lower strobe ignored", dac_code, b);
   endtask

   task automatic t_serial_lsb();
      logic [15:0] w = 16'h5A0F;
      for (int i = 0; i < 16; i++) shift_bit(w[i], 1'b0);
      pulse_load();
      chk("R2 lsb first word", dac_code, w);
      chk("R4 ser_out lsb end", {15'b0, ser_out}, {15'b0, w[0]});
   endtask

   task automatic t_clear(input logic bip, input logic [15:0] exp);
      @(negedge clk);
      ser_sel = 1'b0; cs_n = 1'b1; lo_en_n = bip;
      idle(5);
      #3 clr_n = 1'b0;
      #2 chk(bip ? "R6 bipolar clear immediate" : "R6 unipolar clear immediate", dac_code, exp);
      idle(4);
      clr_n = 1'b1;
      idle(5);
      lo_en_n = 1'b1;
      chk("R6 code held after release", dac_code, exp);
      pulse_load();
      chk("R6 input register cleared", dac_code, exp);
   endtask

   initial begin
      bit done = 1'b0;
      rst_n = 1'b0; bus_d = '0; cs_n = 1'b1; hi_en_n = 1'b1; lo_en_n = 1'b1;
      ser_sel = 1'b0; load_n = 1'b1; clr_n = 1'b1;
      idle(5);
      rst_n = 1'b1;
      idle(5);
      fork
         begin
            t_reset();
            t_bytes();
            t_cs_gate();
            t_serial_msb();
            t_serial_lsb();
            t_clear(1'b1, 16'h8000);
            byte_wr(1'b1, 8'h42);
            pulse_load();
            t_clear(1'b0, 16'h0000);
            done = 1'b1;
         end
         begin
            repeat (100000) @(posedge clk);
         end
      join_any
      disable fork;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=expired expected=finished");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule